// File: doc/BRIEF.md
# Serial Augmented-Message CRC Engine

This block computes and verifies a cyclic redundancy check one bit per clock. It uses the augmented-message method. A remainder register that is one bit wider than the CRC takes each accepted data bit at its bottom end. Whenever the bit shifted into the top position is 1, the register is XORed with the complete generator, including the generator's leading 1. This leaves the top bit clear after every step. In generate mode, the engine runs W zero bits through the same step once the last data bit is in. The low W bits that remain form the CRC.

In check mode the caller streams a whole codeword: the message followed by the raw CRC. A zero remainder marks the codeword as intact. The datapath is the same in both modes. The parameters set the CRC width, the generator, the value loaded at start, a value XORed into the generated CRC, and whether the generated CRC is presented bit-reversed. A start pulse begins a run and latches the mode. Holding the valid strobe low pauses the engine.

Top module: `crc_serial_aug`

## Requirements
- R1: After reset, `done`, `pass` and `crc_out` are 0.
- R2: In generate mode (`mode`=0), `crc_out` is the low W bits of the remainder after the data bits and then W zero bits. It is XORed with XOROUT and bit-reversed when OUT_REFLECT=1. With generator 10011 (W=4), INIT 0 and data 0110111 (first bit leftmost), the CRC is 0110.
- R3: Each step shifts one bit into the bottom of the (W+1)-bit remainder. When the new top bit is 1, the register is XORed with the full generator, so the top bit is 0 after every step.
- R4: A `start` pulse loads INIT, latches `mode` (0 = generate, 1 = check) and abandons any run in progress. Changes to `mode` after `start` have no effect on the run.
- R5: During data entry, a cycle with `in_valid` low leaves the remainder unchanged, and `in_bit` and `in_last` are ignored in that cycle.
- R6: `done` is a one-cycle pulse. In generate mode it is high in the cycle that follows the W-th padding edge after the edge that took the bit marked `in_last`. In check mode it is high in the cycle right after that edge.
- R7: In check mode, `pass` is 1 with `done` exactly when the raw W-bit remainder of the codeword is zero, and `crc_out` shows that raw remainder without XOROUT or reversal. `pass` is 0 whenever `done` is 0 and in generate mode.
- R8: A nonzero INIT, XOROUT and OUT_REFLECT shape the generated CRC. A message followed by its raw remainder still checks as zero.
- R9: Padding advances one bit per clock whatever `in_valid`, `in_bit` and `in_last` do, and inputs after the last bit do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run: load INIT and latch mode |
| mode | input | 1 | 0 = generate, 1 = check |
| in_valid | input | 1 | Data bit strobe |
| in_bit | input | 1 | Serial data bit |
| in_last | input | 1 | Marks the final data or codeword bit |
| crc_out | output | W | Generated CRC or raw check remainder |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Codeword intact, valid while done is high |

## Verification
The engine is tried with messages of 1 to 32 bits: the worked example, an all-zero byte, an all-ones word, and irregular values. Two configurations run side by side, one plain 4-bit and one 8-bit with a nonzero start value, final XOR and output reversal. This separates the generator XOR from the effect of INIT, XOROUT and reversal. Each generated CRC is appended to its message and checked again to confirm a zero remainder. A one-bit-corrupted codeword is also checked, which separates pass from fail. Runs with stall cycles, junk inputs during padding, a mode flip after start and an abandoned run show that paused or ignored inputs leave the remainder untouched.

// File: rtl/crc_pkg.sv
package crc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_PAD  = 2'd2
  } phase_t;

  typedef enum logic {
    MODE_GEN   = 1'b0,
    MODE_CHECK = 1'b1
  } mode_t;
endpackage

// File: rtl/crc_step.sv
// One augmented-division step: shift a bit in at the bottom, then reduce
// by the full generator if the top position became 1.
module crc_step #(
  parameter int         W    = 4,
  parameter logic [W:0] POLY = 5'b10011
) (
  input  logic [W:0] cur,
  input  logic       din,
  output logic [W:0] nxt
);
  logic [W:0] shifted;

  always_comb begin
    shifted = {cur[W-1:0], din};
    nxt     = shifted[W] ? (shifted ^ POLY) : shifted;
  end
endmodule

// File: rtl/crc_ctrl.sv
// Run sequencing: data entry, W-bit zero padding, completion strobe.
module crc_ctrl
  import crc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   mode,
  input  logic   in_valid,
  input  logic   in_last,
  output phase_t phase,
  output mode_t  mode_q,
  output logic   shift_en,
  output logic   zero_fill,
  output logic   finish
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] PAD_LAST = CW'(W - 1);

  phase_t        phase_q;
  logic [CW-1:0] pad_cnt;

  assign phase = phase_q;

  always_comb begin
    shift_en  = 1'b0;
    zero_fill = 1'b0;
    finish    = 1'b0;
    if (!start) begin
      case (phase_q)
        PH_DATA: begin
          shift_en = in_valid;
          finish   = in_valid && in_last && (mode_q == MODE_CHECK);
        end
        PH_PAD: begin
          shift_en  = 1'b1;
          zero_fill = 1'b1;
          finish    = (pad_cnt == PAD_LAST);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      pad_cnt <= '0;
      mode_q  <= MODE_GEN;
    end else if (start) begin
      phase_q <= PH_DATA;
      pad_cnt <= '0;
      mode_q  <= mode_t'(mode);
    end else begin
      case (phase_q)
        PH_DATA: begin
          if (in_valid && in_last) begin
            phase_q <= (mode_q == MODE_CHECK) ? PH_IDLE : PH_PAD;
            pad_cnt <= '0;
          end
        end
        PH_PAD: begin
          if (pad_cnt == PAD_LAST) begin
            phase_q <= PH_IDLE;
          end else begin
            pad_cnt <= pad_cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/crc_fmt.sv
// Output shaping: final XOR and optional reversal for generated CRCs,
// raw remainder for checks.
module crc_fmt #(
  parameter int           W           = 4,
  parameter logic [W-1:0] XOROUT      = '0,
  parameter bit           OUT_REFLECT = 1'b0
) (
  input  logic [W-1:0] raw,
  input  logic         is_check,
  output logic [W-1:0] fmt_out
);
  logic [W-1:0] xored;
  logic [W-1:0] ordered;

  assign xored = raw ^ XOROUT;

  generate
    if (OUT_REFLECT) begin : g_rev
      for (genvar gi = 0; gi < W; gi++) begin : g_bit
        assign ordered[gi] = xored[W-1-gi];
      end
    end else begin : g_fwd
      assign ordered = xored;
    end
  endgenerate

  assign fmt_out = is_check ? raw : ordered;
endmodule

// File: rtl/crc_serial_aug.sv
module crc_serial_aug
  import crc_pkg::*;
#(
  parameter int           W           = 4,
  parameter logic [W:0]   POLY        = 5'b10011,
  parameter logic [W-1:0] INIT        = '0,
  parameter logic [W-1:0] XOROUT      = '0,
  parameter bit           OUT_REFLECT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         mode,
  input  logic         in_valid,
  input  logic         in_bit,
  input  logic         in_last,
  output logic [W-1:0] crc_out,
  output logic         done,
  output logic         pass
);
  phase_t       phase;
  mode_t        mode_q;
  logic         shift_en;
  logic         zero_fill;
  logic         finish;
  logic         step_bit;
  logic [W:0]   rem_q;
  logic [W:0]   rem_nx;
  logic [W-1:0] fmt;

  crc_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mode      (mode),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .phase     (phase),
    .mode_q    (mode_q),
    .shift_en  (shift_en),
    .zero_fill (zero_fill),
    .finish    (finish)
  );

  assign step_bit = zero_fill ? 1'b0 : in_bit;

  crc_step #(.W(W), .POLY(POLY)) u_step (
    .cur (rem_q),
    .din (step_bit),
    .nxt (rem_nx)
  );

  crc_fmt #(.W(W), .XOROUT(XOROUT), .OUT_REFLECT(OUT_REFLECT)) u_fmt (
    .raw      (rem_nx[W-1:0]),
    .is_check (mode_q == MODE_CHECK),
    .fmt_out  (fmt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      done    <= 1'b0;
      pass    <= 1'b0;
      crc_out <= '0;
    end else begin
      done <= 1'b0;
      pass <= 1'b0;
      if (start) begin
        rem_q <= {1'b0, INIT};
      end else if (shift_en) begin
        rem_q <= rem_nx;
      end
      if (finish) begin
        done    <= 1'b1;
        pass    <= (mode_q == MODE_CHECK) && (rem_nx[W-1:0] == '0);
        crc_out <= fmt;
      end
    end
  end
endmodule

// File: rtl/crc_serial_aug_chk.sv
module crc_serial_aug_chk
  import crc_pkg::*;
#(
  parameter int           W    = 4,
  parameter logic [W-1:0] INIT = '0
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         in_valid,
  input logic         done,
  input logic         pass,
  input phase_t       phase,
  input logic [W:0]   rem_q,
  input logic [W-1:0] crc_out
);
  AST_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    rem_q[W] == 1'b0); // R3

  AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
    start |=> (rem_q == {1'b0, INIT})); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA && !start && !in_valid) |=> $stable(rem_q)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_PASS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    pass |-> done); // R7

  AST_PASS_ZERO: assert property (@(posedge clk) disable iff (rst)
    pass |-> (crc_out == '0)); // R7
endmodule

bind crc_serial_aug crc_serial_aug_chk #(.W(W), .INIT(INIT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .in_valid (in_valid),
  .done     (done),
  .pass     (pass),
  .phase    (phase),
  .rem_q    (rem_q),
  .crc_out  (crc_out)
);

// File: tb/tb_crc_serial_aug.sv
`timescale 1ns/1ps
module tb_crc_serial_aug;
  localparam int             WA = 4;
  localparam logic [WA:0]    PA = 5'b10011;
  localparam int             WB = 8;
  localparam logic [WB:0]    PB = 9'h107;
  localparam logic [WB-1:0]  IB = 8'hFF;
  localparam logic [WB-1:0]  XB = 8'h55;
  localparam int             NV = 6;
  // [37:32] length, [31:0] message (first bit is bit len-1)
  localparam logic [37:0] VEC [NV] = '{
    {6'd7,  32'h0000_0037},
    {6'd1,  32'h0000_0001},
    {6'd8,  32'h0000_0000},
    {6'd16, 32'h0000_A5C3},
    {6'd24, 32'h0012_3456},
    {6'd32, 32'hFFFF_FFFF}
  };

  logic clk = 1'b0;
  logic rst, start, mode, in_valid, in_bit, in_last;
  logic [WA-1:0] crc_a;
  logic [WB-1:0] crc_b;
  logic done_a, pass_a, done_b, pass_b;

  int checks = 0;
  int errors = 0;
  int ja, jb, na, nb;
  logic [WA-1:0] ca;
  logic [WB-1:0] cb;
  logic pa, pb;

  always #2 clk = ~clk;

  crc_serial_aug dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .in_valid(in_valid),
    .in_bit(in_bit), .in_last(in_last), .crc_out(crc_a), .done(done_a), .pass(pass_a)
  );

  crc_serial_aug #(.W(WB), .POLY(PB), .INIT(IB), .XOROUT(XB), .OUT_REFLECT(1'b1)) dut_b (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .in_valid(in_valid),
    .in_bit(in_bit), .in_last(in_last), .crc_out(crc_b), .done(done_b), .pass(pass_b)
  );

  function automatic logic [15:0] model(input int w, input logic [16:0] poly,
                                        input logic [15:0] init, input logic [63:0] m,
                                        input int n, input bit pad);
    logic [16:0] r;
    r = {1'b0, init};
    for (int i = 0; i < n + (pad ? w : 0); i++) begin
      logic b;
      b = (i < n) ? m[n-1-i] : 1'b0;
      r = {r[15:0], b};
      if (r[w]) r = r ^ poly;
    end
    return r[15:0];
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic run(input logic [63:0] m, input int n, input logic md,
                     input int stall, input logic junk);
    @(negedge clk);
    start = 1'b1; mode = md; in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
    start = 1'b0; mode = ~md;   // flipped mode must not matter (R4)
    for (int i = 0; i < n; i++) begin
      if (stall > 0 && (i % stall) == 1) begin
        in_valid = 1'b0; in_bit = ~m[n-1-i]; in_last = 1'b1;   // R5 junk
        @(negedge clk);
      end
      in_valid = 1'b1; in_bit = m[n-1-i]; in_last = (i == n - 1);
      @(negedge clk);
    end
    in_valid = junk; in_bit = junk; in_last = junk;              // R9 junk
    ja = -1; jb = -1; na = 0; nb = 0; ca = '0; cb = '0; pa = 0; pb = 0;
    for (int j = 0; j < 20; j++) begin
      if (done_a) begin na++; ja = j; ca = crc_a; pa = pass_a; end
      else if (pass_a) begin pa = 1'b1; end
      if (done_b) begin nb++; jb = j; cb = crc_b; pb = pass_b; end
      else if (pass_b) begin pb = 1'b1; end
      @(negedge clk);
    end
    in_valid = 1'b0; in_bit = 1'b0; in_last = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] m;
    int n;
    logic [3:0] ra;
    logic [7:0] rb;
    rst = 1'b1; start = 0; mode = 0; in_valid = 0; in_bit = 0; in_last = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset done_a", done_a, 0);
    chk("R1 reset pass_a", pass_a, 0);
    chk("R1 reset crc_a", crc_a, 0);
    chk("R1 reset crc_b", crc_b, 0);

    for (int v = 0; v < NV; v++) begin
      n = int'(VEC[v][37:32]);
      m = {32'h0, VEC[v][31:0]};
      ra = model(WA, 17'(PA), 16'h0, m, n, 1'b1);
      rb = model(WB, 17'(PB), 16'(IB), m, n, 1'b1);
      // generate
      run(m, n, 1'b0, (v % 2 == 1) ? 3 : 0, (v % 3 == 0));
      chk("R2 gen crc A", ca, ra);
      chk("R6 gen done index A", ja, WA);
      chk("R6 gen done count A", na, 1);
      chk("R7 gen pass A low", pa, 0);
      chk("R8 gen crc B", cb, rev8(rb ^ XB));
      chk("R6 gen done index B", jb, WB);
      if (v == 0) chk("R2 worked example", ca, 4'b0110);
      // check A codeword
      run((m << WA) | ra, n + WA, 1'b1, (v % 2 == 0) ? 4 : 0, 1'b1);
      chk("R7 check pass A", pa, 1);
      chk("R7 check raw A", ca, 0);
      chk("R6 check done index A", ja, 0);
      chk("R7 check raw B", cb, model(WB, 17'(PB), 16'(IB), (m << WA) | ra, n + WA, 1'b0));
      // check B codeword
      run((m << WB) | rb, n + WB, 1'b1, 0, 1'b0);
      chk("R8 check pass B", pb, 1);
      chk("R6 check done count B", nb, 1);
      // corrupted A codeword
      if (v % 2 == 0) begin
        run(((m << WA) | ra) ^ 64'h2, n + WA, 1'b1, 0, 1'b0);
        chk("R7 corrupt pass A", pa, 0);
        chk("R7 corrupt raw A", ca, model(WA, 17'(PA), 16'h0, ((m << WA) | ra) ^ 64'h2, n + WA, 1'b0));
      end
    end

    // R4: abandoned run, then a fresh one
    @(negedge clk); start = 1; mode = 0;
    @(negedge clk); start = 0;
    for (int i = 0; i < 3; i++) begin in_valid = 1; in_bit = 1; in_last = 0; @(negedge clk); end
    m = 64'h5A; n = 8;
    run(m, n, 1'b0, 0, 1'b0);
    chk("R4 restart crc A", ca, model(WA, 17'(PA), 16'h0, m, n, 1'b1));
    chk("R4 restart crc B", cb, rev8(model(WB, 17'(PB), 16'(IB), m, n, 1'b1) ^ XB));

    // R9: long stalls plus junk during padding
    run(m, n, 1'b0, 2, 1'b1);
    chk("R9 junk pad crc A", ca, model(WA, 17'(PA), 16'h0, m, n, 1'b1));
    chk("R5 stall crc B", cb, rev8(model(WB, 17'(PB), 16'(IB), m, n, 1'b1) ^ XB));

    // R1: reset after activity
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R1 re-reset crc_a", crc_a, 0);
    chk("R1 re-reset done_b", done_b, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule